// File: doc/BRIEF.md
# Reversible Binary Counter with Previous-State Restore

This block is a synchronous binary counter of parameterised width that steps up or down by one on each enabled clock cycle. It takes the usual controls: a synchronous clear, a parallel load, a count enable and a direction select. The state is presented on an output that can be sampled in any cycle. A terminal-count flag marks the last value in the direction currently selected.

The block keeps a second register that holds the value the counter had before its most recent step. When the direction select no longer matches the direction of the previous step, the next state is taken from that register and no increment or decrement is computed. The previous value is exactly the value the reversed step needs, so the select logic only chooses between the arithmetic result and the stored copy. A clear or a load discards the stored copy. The first step after either one is therefore computed arithmetically. A parameter selects whether this restore path is built at all. The output sequence is the same with or without it. Only the logic behind the state register differs.

Top module: `rev_counter`

## Requirements
- R1: With `cnt_en` high and `dn` low the state increases by one per clock; with `dn` high (value 1) it decreases by one per clock.
- R2: With `cnt_en` low and no clear or load, the state keeps its value whatever `dn` does.
- R3: `rst` high at a clock edge sets the state to zero, even when `load` or `cnt_en` is also high.
- R4: `load` high (with `rst` low) copies `din` into the state at the clock edge, even when `cnt_en` is also high.
- R5: `tc` is high exactly when the state is all ones and `dn` is low, or the state is all zeros and `dn` is high.
- R6: A step whose direction differs from the direction of the immediately preceding step returns the state to the value it held before that preceding step.
- R7: The first step after a clear or a load moves by one from the cleared or loaded value in the selected direction, whatever direction was used before.
- R8: Counting wraps modulo 2^WIDTH: up from all ones gives zero, and down from zero gives all ones.
- R9: Both settings of `RESTORE_MODE` (1 = restore from the stored previous value, 0 = always compute) give the same `q` and `tc` sequence for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear, active high, highest priority |
| load | input | 1 | Parallel load strobe, active high |
| din | input | WIDTH | Value to load |
| cnt_en | input | 1 | Count enable, active high |
| dn | input | 1 | Direction select: 0 counts up, 1 counts down |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal count for the selected direction |

## Verification
The bench builds two copies with WIDTH set to 8: one with the restore path (RESTORE_MODE 1) and one without it (RESTORE_MODE 0). Both are checked against the same plain up/down reference. The eight-bit width puts both wrap boundaries and both terminal-count values within a few loaded steps. Running the two variants side by side shows that restoring from the stored value never departs from the arithmetic result, including across reversals at the wrap points and directly after loads.

// File: rtl/rc_pkg.sv
package rc_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } rc_dir_e;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_CLEAR = 2'd1,
      OP_LOAD  = 2'd2,
      OP_STEP  = 2'd3
   } rc_op_e;

   function automatic rc_op_e rc_decode(input logic clr, input logic ld, input logic en);
      if (clr)     return OP_CLEAR;
      else if (ld) return OP_LOAD;
      else if (en) return OP_STEP;
      else         return OP_HOLD;
   endfunction

endpackage

// File: rtl/rc_ctrl.sv
module rc_ctrl
   import rc_pkg::*;
(
   input  logic    rst,
   input  logic    load,
   input  logic    cnt_en,
   input  logic    dn,
   output rc_op_e  op,
   output rc_dir_e dir
);
   always_comb begin
      op  = rc_decode(rst, load, cnt_en);
      dir = dn ? DIR_DOWN : DIR_UP;
   end
endmodule

// File: rtl/rc_stepper.sv
module rc_stepper
   import rc_pkg::*;
#(
   parameter int WIDTH = 16
)(
   input  logic [WIDTH-1:0] cur,
   input  rc_dir_e          dir,
   output logic [WIDTH-1:0] nxt
);
   localparam int CHAIN = WIDTH + 1;

   logic [CHAIN-1:0] ones_below;
   logic [CHAIN-1:0] zeros_below;
   logic [WIDTH-1:0] inc_val;
   logic [WIDTH-1:0] dec_val;

   assign ones_below[0]  = 1'b1;
   assign zeros_below[0] = 1'b1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign ones_below[i+1]  = ones_below[i]  &  cur[i];
      assign zeros_below[i+1] = zeros_below[i] & ~cur[i];
      assign inc_val[i] = cur[i] ^ ones_below[i];
      assign dec_val[i] = cur[i] ^ zeros_below[i];
   end

   logic unused_chain;
   assign unused_chain = ones_below[WIDTH] ^ zeros_below[WIDTH];

   assign nxt = (dir == DIR_DOWN) ? dec_val : inc_val;
endmodule

// File: rtl/rc_shadow.sv
module rc_shadow
   import rc_pkg::*;
#(
   parameter int WIDTH        = 16,
   parameter int RESTORE_MODE = 1
)(
   input  logic             clk,
   input  rc_op_e           op,
   input  rc_dir_e          dir,
   input  logic [WIDTH-1:0] state,
   output logic             restore,
   output logic [WIDTH-1:0] prev_val
);
   if (RESTORE_MODE != 0) begin : g_keep
      logic [WIDTH-1:0] prev_q;
      logic             prev_vld;
      rc_dir_e          last_dir;

      always_ff @(posedge clk) begin
         unique case (op)
            OP_CLEAR, OP_LOAD: begin
               prev_vld <= 1'b0;
               last_dir <= DIR_UP;
            end
            OP_STEP: begin
               prev_q   <= state;
               prev_vld <= 1'b1;
               last_dir <= dir;
            end
            default: ;
         endcase
      end

      assign restore  = prev_vld && (dir != last_dir);
      assign prev_val = prev_q;
   end else begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, op, dir, state};
      assign restore   = 1'b0;
      assign prev_val  = '0;
   end
endmodule

// File: rtl/rc_tc.sv
module rc_tc
   import rc_pkg::*;
#(
   parameter int WIDTH = 16
)(
   input  logic [WIDTH-1:0] state,
   input  rc_dir_e          dir,
   output logic             tc
);
   logic all_one;
   logic all_zero;

   assign all_one  = &state;
   assign all_zero = ~|state;
   assign tc = (dir == DIR_DOWN) ? all_zero : all_one;
endmodule

// File: rtl/rev_counter.sv
module rev_counter
   import rc_pkg::*;
#(
   parameter int WIDTH        = 16,
   parameter int RESTORE_MODE = 1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   input  logic             cnt_en,
   input  logic             dn,
   output logic [WIDTH-1:0] q,
   output logic             tc
);
   localparam logic [WIDTH-1:0] ZERO = '0;

   if (WIDTH < 2) begin : g_bad_width
      $error("rev_counter: WIDTH must be at least 2");
   end
   if (RESTORE_MODE != 0 && RESTORE_MODE != 1) begin : g_bad_mode
      $error("rev_counter: RESTORE_MODE must be 0 or 1");
   end

   rc_op_e           op;
   rc_dir_e          dir;
   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] arith_nxt;
   logic [WIDTH-1:0] prev_val;
   logic             restore;
   logic [WIDTH-1:0] step_nxt;

   rc_ctrl u_ctrl (
      .rst    (rst),
      .load   (load),
      .cnt_en (cnt_en),
      .dn     (dn),
      .op     (op),
      .dir    (dir)
   );

   rc_stepper #(.WIDTH(WIDTH)) u_step (
      .cur (state_q),
      .dir (dir),
      .nxt (arith_nxt)
   );

   rc_shadow #(.WIDTH(WIDTH), .RESTORE_MODE(RESTORE_MODE)) u_shadow (
      .clk      (clk),
      .op       (op),
      .dir      (dir),
      .state    (state_q),
      .restore  (restore),
      .prev_val (prev_val)
   );

   rc_tc #(.WIDTH(WIDTH)) u_tc (
      .state (state_q),
      .dir   (dir),
      .tc    (tc)
   );

   assign step_nxt = restore ? prev_val : arith_nxt;

   always_ff @(posedge clk) begin
      unique case (op)
         OP_CLEAR: state_q <= ZERO;
         OP_LOAD:  state_q <= din;
         OP_STEP:  state_q <= step_nxt;
         default:  state_q <= state_q;
      endcase
   end

   assign q = state_q;
endmodule

// File: rtl/rev_counter_chk.sv
module rev_counter_chk #(
   parameter int WIDTH = 16
)(
   input logic             clk,
   input logic             rst,
   input logic             load,
   input logic [WIDTH-1:0] din,
   input logic             cnt_en,
   input logic             dn,
   input logic [WIDTH-1:0] q,
   input logic             tc
);
   localparam logic [WIDTH-1:0] ONE  = 1;
   localparam logic [WIDTH-1:0] ONES = '1;

   AST_CLEAR_ZERO: assert property (@(posedge clk) rst |=> q == '0); // R3

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(din)); // R4

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!load && !cnt_en) |=> $stable(q)); // R2

   AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt_en && !dn) |=> q == $past(q) + ONE); // R1

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt_en && dn) |=> q == $past(q) - ONE); // R1

   AST_TC_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt_en && !dn && tc) |=> q == '0); // R5

   AST_TC_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt_en && dn && tc) |=> q == ONES); // R5

   AST_REVERSE_RESTORE: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt_en && $past(!rst && !load && cnt_en) && (dn != $past(dn)))
      |=> q == $past(q, 2)); // R6
endmodule

bind rev_counter rev_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/rev_counter_test.sv
module rev_counter_test;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   typedef struct {
      logic [W-1:0] q;
      logic         tc;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load = 1'b0;
   logic [W-1:0] din = '0;
   logic         cnt_en = 1'b0;
   logic         dn = 1'b0;
   logic [W-1:0] q_a, q_b;
   logic         tc_a, tc_b;

   int checks = 0;
   int errors = 0;
   item_t sb[$];
   logic [W-1:0] model = '0;
   logic [15:0]  lfsr = 16'hACE1;

   always #(CLK_P/2) clk = ~clk;

   rev_counter #(.WIDTH(W), .RESTORE_MODE(1)) uut (
      .clk(clk), .rst(rst), .load(load), .din(din), .cnt_en(cnt_en), .dn(dn),
      .q(q_a), .tc(tc_a));

   rev_counter #(.WIDTH(W), .RESTORE_MODE(0)) uut_alt (
      .clk(clk), .rst(rst), .load(load), .din(din), .cnt_en(cnt_en), .dn(dn),
      .q(q_b), .tc(tc_b));

   task automatic step(input logic r, input logic l, input logic [W-1:0] d,
                       input logic e, input logic ds, input string tag);
      item_t it;
      @(negedge clk);
      rst = r; load = l; din = d; cnt_en = e; dn = ds;
      if (r)      model = '0;
      else if (l) model = d;
      else if (e) model = ds ? model - 1'b1 : model + 1'b1;
      it.q   = model;
      it.tc  = ds ? (model == '0) : (model == '1);
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic compare(input string who, input logic [W-1:0] q, input logic t, input item_t it);
      checks++;
      if (q !== it.q || t !== it.tc) begin
         errors++;
         $display("FAIL %s %s: q=%h tc=%b expected q=%h tc=%b", it.tag, who, q, t, it.q, it.tc);
      end
   endtask

   initial begin : monitor
      item_t it;
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (sb.size() > 0) begin
            it = sb.pop_front();
            compare("uut", q_a, tc_a, it);
            compare("uut_alt R9", q_b, tc_b, it);
         end
      end
   end

   initial begin : watchdog
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog: run did not end, expected end before timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : driver
      // R3 clear, also with load and enable high
      step(1, 0, 8'h00, 0, 0, "R3 reset");
      step(1, 1, 8'h77, 1, 0, "R3 reset over load");
      // R4 load, also with enable high
      step(0, 1, 8'h5A, 0, 0, "R4 load");
      step(0, 1, 8'h20, 1, 1, "R4 load over count");
      // R1 up and down
      for (int i = 0; i < 5; i++) step(0, 0, 8'h00, 1, 0, "R1 up");
      // R2 hold while dn toggles
      for (int i = 0; i < 4; i++) step(0, 0, 8'hFF, 0, i[0], "R2 hold");
      // R6 reversals
      for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 1, 1, "R6 reverse down");
      step(0, 0, 8'h00, 1, 0, "R6 reverse up");
      for (int i = 0; i < 8; i++) step(0, 0, 8'h00, 1, i[0], "R6 alternate");
      // R8 / R5 wrap upward and downward
      step(0, 1, 8'hFE, 0, 0, "R4 load FE");
      step(0, 0, 8'h00, 1, 0, "R5 tc at FF up");
      step(0, 0, 8'h00, 1, 0, "R8 wrap up");
      step(0, 0, 8'h00, 1, 1, "R6 reverse across wrap");
      step(0, 0, 8'h00, 1, 0, "R6 reverse back");
      step(0, 1, 8'h01, 0, 1, "R4 load 01");
      step(0, 0, 8'h00, 1, 1, "R5 tc at 00 down");
      step(0, 0, 8'h00, 1, 1, "R8 wrap down");
      // R5 terminal count follows dn while idle
      step(0, 1, 8'h00, 0, 0, "R5 zero with up select");
      step(0, 0, 8'h00, 0, 1, "R5 zero with down select");
      step(0, 0, 8'h00, 0, 0, "R5 zero back to up");
      // R7 first step after load/clear is arithmetic
      step(0, 1, 8'h10, 0, 0, "R4 load 10");
      step(0, 0, 8'h00, 1, 1, "R7 down");
      step(0, 0, 8'h00, 1, 1, "R7 down");
      step(0, 1, 8'h30, 0, 0, "R4 load 30");
      step(0, 0, 8'h00, 1, 0, "R7 up after load");
      step(0, 0, 8'h00, 1, 1, "R6 reverse after load");
      step(0, 0, 8'h00, 1, 0, "R7 up");
      step(1, 0, 8'h00, 0, 0, "R3 reset mid run");
      step(0, 0, 8'h00, 1, 1, "R7 down after reset");
      // mixed pseudo-random run
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(0, lfsr[7:0] == 8'h3C, lfsr[15:8], lfsr[2] | lfsr[5], lfsr[9], "R1 R6 mixed");
      end
      repeat (4) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule